// File: doc/BRIEF.md
# TLP Request Completer Bridge

This block sits behind the receive side of a PCIe endpoint. It takes request TLPs, one dword per beat, from a streaming input. It decodes the header, and each legal request becomes one single-word access on a memory-mapped port. Such an access reaches either the configuration space or the small register file of one of two functions. The bridge serves both functions' configuration spaces itself, without a standard configuration block behind it. Requests that need an answer receive a completion TLP on a streaming output, with a status chosen by per-type rules.

The bridge handles one request at a time. It captures the whole TLP and decodes it. It then issues the memory-mapped access, waits for its acknowledge, and sends the completion. It takes no new TLP until all of that is finished. Posted requests that break the rules are discarded without any trace at the ports.

Top module: `tlp_req_completer`

## Requirements
- R1: A Type 0 Configuration Read (Type field 5'b00100, Fmt 3'b000) with length 1 to function 0 or 1 issues one memory-mapped read with mm_cfg=1, mm_func set to the function, and mm_addr set to the 10-bit register number (dword 2 bits 11:2). The memory-mapped request stays asserted and unchanged until mm_ack. The read is answered with a four-beat completion with data (Fmt 3'b010, Type 5'b01010, length 1) with status 3'b000 and the acknowledged data as its fourth beat.
- R2: A valid Type 0 Configuration Write (Fmt 3'b010) issues one memory-mapped write carrying the payload dword and the first-dword byte enables (dword 1 bits 3:0). It is answered with a three-beat completion without data (Fmt 3'b000, length 0) with status 3'b000.
- R3: A configuration request is answered with status 3'b001 (Unsupported Request) and no memory-mapped access in any of these cases: the function number (dword 2 bits 18:16) is above 1, the length is not 1, the header is 4 dwords, or the request is Type 1 (Type 5'b00101).
- R4: A Memory Read (Type 5'b00000, Fmt 3'b000) of length 1 inside the 2 MB window at MEM_BASE issues a memory-mapped read with mm_cfg=0. mm_func is address bit 20 (lower MB is function 0, upper MB is function 1) and mm_addr is address bit 2, which selects one of two 32-bit registers. The read is answered with a completion with data and status 3'b000.
- R5: A Memory Write (Fmt 3'b010) of length 1 inside the window issues one memory-mapped write with mm_cfg=0 and sends no completion. mm_read and mm_write are never high together.
- R6: A Memory Write with a length other than 1 is discarded: no memory-mapped access and no completion.
- R7: Every Message (Type[4:3]=2'b10) is discarded without access or completion, whether or not it carries data.
- R8: A Memory Read with a length other than 1 (length 0 meaning 1024) is answered with status 3'b100 (Completer Abort) and no data. This takes priority over the window check.
- R9: A single-dword Memory Read outside the window, or one with a 4-dword header, is answered with status 3'b001. A Memory Write outside the window, or one with a 4-dword header, is discarded.
- R10: Completion dword 1 is {Completer ID, status, 1'b0, byte count 12'd4}. The Completer ID is {CPL_BUS_DEV, 3-bit function}. Completion dword 2 is {Requester ID, Tag, 1'b0, lower address} with Requester ID and Tag copied from the request. The lower address is 0 for configuration requests and {address[6:2],2'b00} for memory reads; for 4-dword headers the address is dword 3 and the function is 0. Beats hold while tx_ready is low.
- R11: rx_ready is low from the cycle after the last beat of a TLP is accepted until the access is acknowledged and the last completion beat is accepted. It is never high while a memory-mapped request or tx_valid is high.
- R12: After reset, rx_ready is 1 and tx_valid, mm_read and mm_write are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive beat valid |
| rx_ready | output | 1 | Bridge accepts a receive beat |
| rx_sop | input | 1 | First beat of a TLP |
| rx_eop | input | 1 | Last beat of a TLP |
| rx_data | input | 32 | Receive dword |
| mm_read | output | 1 | Memory-mapped read request |
| mm_write | output | 1 | Memory-mapped write request |
| mm_cfg | output | 1 | 1: configuration space, 0: register file |
| mm_func | output | 1 | Target function |
| mm_addr | output | 10 | Register number or register index |
| mm_be | output | 4 | Byte enables |
| mm_wdata | output | 32 | Write data |
| mm_ack | input | 1 | Access finished; read data valid |
| mm_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Completion beat valid |
| tx_ready | input | 1 | Completion beat accepted |
| tx_sop | output | 1 | First completion beat |
| tx_eop | output | 1 | Last completion beat |
| tx_data | output | 32 | Completion dword |

## Verification
A wrong decode state shows at the ports in one of two places. It shows at the memory-mapped port a cycle after the TLP has been captured, as an access with the wrong space, function or register. It also shows a cycle later on the transmit stream, as a completion with the wrong status or length. A dropped request that leaks, or a legal one that vanishes, breaks the strict ordering of expected accesses and beats at once: the next transaction mismatches or the queue is not empty at idle. A stuck sequencing state shows as rx_ready staying low, or rising while a request or a completion beat is still pending, in the very cycle it happens. The bench drives tx_ready low on some cycles to test the hold rule.

// File: rtl/tlpc_pkg.sv
package tlpc_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned REG_AW    = 10;
  localparam int unsigned CAP_BEATS = 4;
  localparam int unsigned NBW       = $clog2(CAP_BEATS + 1);

  localparam logic [4:0] TY_MEM  = 5'b00000;
  localparam logic [4:0] TY_CFG0 = 5'b00100;
  localparam logic [4:0] TY_CFG1 = 5'b00101;
  localparam logic [4:0] TY_CPL  = 5'b01010;

  typedef enum logic [2:0] {
    CST_SC = 3'b000,
    CST_UR = 3'b001,
    CST_CA = 3'b100
  } cpl_status_e;

  typedef struct packed {
    logic              mm_en;
    logic              mm_wr;
    logic              mm_cfg;
    logic              mm_func;
    logic [REG_AW-1:0] mm_addr;
    logic [3:0]        mm_be;
    logic              cpl_en;
    logic              cpl_data;
    cpl_status_e       status;
    logic [2:0]        cpl_func;
    logic [6:0]        lower_addr;
  } req_dec_t;
endpackage

// File: rtl/tlpc_rx_capture.sv
module tlpc_rx_capture
  import tlpc_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          accept,
  input  logic                          sop,
  input  logic [DW-1:0]                 data,
  output logic [CAP_BEATS-1:0][DW-1:0]  cap
);
  logic [NBW-1:0] idx_q;
  logic [NBW-1:0] widx;

  assign widx = sop ? '0 : idx_q;

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else if (accept) idx_q <= (widx == NBW'(CAP_BEATS)) ? widx : widx + 1'b1;
  end

  for (genvar g = 0; g < CAP_BEATS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) cap[g] <= '0;
      else if (accept && widx == NBW'(g)) cap[g] <= data;
    end
  end
endmodule

// File: rtl/tlpc_decode.sv
module tlpc_decode
  import tlpc_pkg::*;
#(
  parameter logic [31:0] MEM_BASE = 32'h4000_0000,
  parameter int unsigned WIN_LOG2 = 20
) (
  input  logic [CAP_BEATS-1:0][DW-1:0] cap,
  output req_dec_t                     dec
);
  logic [2:0] fmt;
  logic [4:0] ty;
  logic       one_dw;
  logic       in_win;

  assign fmt    = cap[0][31:29];
  assign ty     = cap[0][28:24];
  assign one_dw = (cap[0][9:0] == 10'd1);
  assign in_win = (cap[2][31:WIN_LOG2+1] == MEM_BASE[31:WIN_LOG2+1]);

  always_comb begin
    dec       = '0;
    dec.mm_be = cap[1][3:0];
    if (ty == TY_CFG0 || ty == TY_CFG1) begin
      dec.cpl_en   = 1'b1;
      dec.cpl_func = cap[2][18:16];
      if (ty == TY_CFG0 && cap[2][18:17] == 2'b00 && one_dw && !fmt[0]) begin
        dec.mm_en    = 1'b1;
        dec.mm_wr    = fmt[1];
        dec.mm_cfg   = 1'b1;
        dec.mm_func  = cap[2][16];
        dec.mm_addr  = cap[2][11:2];
        dec.cpl_data = !fmt[1];
      end else begin
        dec.status = CST_UR;
      end
    end else if (ty == TY_MEM) begin
      dec.mm_func = cap[2][WIN_LOG2];
      dec.mm_addr = REG_AW'(cap[2][2]);
      if (fmt[1]) begin
        dec.mm_en = !fmt[0] && one_dw && in_win;
        dec.mm_wr = 1'b1;
      end else begin
        dec.cpl_en     = 1'b1;
        dec.cpl_func   = fmt[0] ? 3'd0 : {2'b00, cap[2][WIN_LOG2]};
        dec.lower_addr = fmt[0] ? {cap[3][6:2], 2'b00} : {cap[2][6:2], 2'b00};
        if (!one_dw) begin
          dec.status = CST_CA;
        end else if (fmt[0] || !in_win) begin
          dec.status = CST_UR;
        end else begin
          dec.mm_en    = 1'b1;
          dec.cpl_data = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tlpc_cpl_tx.sv
module tlpc_cpl_tx
  import tlpc_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load,
  input  logic [CAP_BEATS-1:0][DW-1:0] words,
  input  logic [NBW-1:0]               nbeats,
  input  logic                         tx_ready,
  output logic                         tx_valid,
  output logic                         tx_sop,
  output logic                         tx_eop,
  output logic [DW-1:0]                tx_data,
  output logic                         done
);
  logic [CAP_BEATS-1:0][DW-1:0] buf_q;
  logic [NBW-1:0]               left_q;
  logic                         fire;

  assign fire    = tx_valid && tx_ready;
  assign done    = fire && tx_eop;
  assign tx_data = buf_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q    <= '0;
      left_q   <= '0;
      tx_valid <= 1'b0;
      tx_sop   <= 1'b0;
      tx_eop   <= 1'b0;
    end else if (load) begin
      buf_q    <= words;
      left_q   <= nbeats;
      tx_valid <= 1'b1;
      tx_sop   <= 1'b1;
      tx_eop   <= (nbeats == NBW'(1));
    end else if (fire) begin
      buf_q  <= buf_q >> DW;
      left_q <= left_q - 1'b1;
      tx_sop <= 1'b0;
      tx_eop <= (left_q == NBW'(2));
      if (left_q == NBW'(1)) tx_valid <= 1'b0;
    end
  end

  assert_tx_hold_R10: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sop));
endmodule

// File: rtl/tlp_req_completer.sv
module tlp_req_completer
  import tlpc_pkg::*;
#(
  parameter logic [31:0] MEM_BASE    = 32'h4000_0000,
  parameter int unsigned WIN_LOG2    = 20,
  parameter logic [12:0] CPL_BUS_DEV = 13'h0A3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              rx_sop,
  input  logic              rx_eop,
  input  logic [DW-1:0]     rx_data,
  output logic              mm_read,
  output logic              mm_write,
  output logic              mm_cfg,
  output logic              mm_func,
  output logic [REG_AW-1:0] mm_addr,
  output logic [3:0]        mm_be,
  output logic [DW-1:0]     mm_wdata,
  input  logic              mm_ack,
  input  logic [DW-1:0]     mm_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_sop,
  output logic              tx_eop,
  output logic [DW-1:0]     tx_data
);
  typedef enum logic [1:0] {ST_RX, ST_DEC, ST_MM, ST_CPL} state_e;

  state_e                       state;
  logic [CAP_BEATS-1:0][DW-1:0] cap;
  logic [CAP_BEATS-1:0][DW-1:0] cw;
  req_dec_t                     dec;
  logic                         rx_fire;
  logic                         cpl_load;
  logic                         cpl_done;
  logic                         unused_bits;

  assign rx_fire     = rx_valid && rx_ready;
  assign unused_bits = ^cap[1][7:0];

  tlpc_rx_capture u_cap (
    .clk(clk), .rst(rst), .accept(rx_fire), .sop(rx_sop), .data(rx_data), .cap(cap)
  );

  tlpc_decode #(.MEM_BASE(MEM_BASE), .WIN_LOG2(WIN_LOG2)) u_dec (
    .cap(cap), .dec(dec)
  );

  always_comb begin
    cw[0] = {dec.cpl_data ? 3'b010 : 3'b000, TY_CPL, 14'd0,
             dec.cpl_data ? 10'd1 : 10'd0};
    cw[1] = {CPL_BUS_DEV, dec.cpl_func, dec.status, 1'b0, 12'd4};
    cw[2] = {cap[1][31:16], cap[1][15:8], 1'b0, dec.lower_addr};
    cw[3] = mm_rdata;
  end

  assign cpl_load = dec.cpl_en &&
                    ((state == ST_DEC && !dec.mm_en) || (state == ST_MM && mm_ack));

  tlpc_cpl_tx u_tx (
    .clk(clk), .rst(rst), .load(cpl_load), .words(cw),
    .nbeats(dec.cpl_data ? NBW'(4) : NBW'(3)), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_data(tx_data),
    .done(cpl_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_RX;
      rx_ready <= 1'b1;
      mm_read  <= 1'b0;
      mm_write <= 1'b0;
      mm_cfg   <= 1'b0;
      mm_func  <= 1'b0;
      mm_addr  <= '0;
      mm_be    <= '0;
      mm_wdata <= '0;
    end else begin
      case (state)
        ST_RX: if (rx_fire && rx_eop) begin
          state    <= ST_DEC;
          rx_ready <= 1'b0;
        end
        ST_DEC: begin
          if (dec.mm_en) begin
            mm_read  <= !dec.mm_wr;
            mm_write <= dec.mm_wr;
            mm_cfg   <= dec.mm_cfg;
            mm_func  <= dec.mm_func;
            mm_addr  <= dec.mm_addr;
            mm_be    <= dec.mm_be;
            mm_wdata <= dec.mm_wr ? cap[3] : '0;
            state    <= ST_MM;
          end else if (dec.cpl_en) begin
            state <= ST_CPL;
          end else begin
            state    <= ST_RX;
            rx_ready <= 1'b1;
          end
        end
        ST_MM: if (mm_ack) begin
          mm_read  <= 1'b0;
          mm_write <= 1'b0;
          state    <= dec.cpl_en ? ST_CPL : ST_RX;
          rx_ready <= !dec.cpl_en;
        end
        default: if (cpl_done) begin
          state    <= ST_RX;
          rx_ready <= 1'b1;
        end
      endcase
    end
  end

  assert_busy_blocks_rx_R11: assert property (@(posedge clk) disable iff (rst)
    (mm_read || mm_write || tx_valid) |-> !rx_ready);

  assert_mm_held_R1: assert property (@(posedge clk) disable iff (rst)
    (mm_read || mm_write) && !mm_ack |=>
      (mm_read || mm_write) && $stable(mm_addr) && $stable(mm_cfg) && $stable(mm_func));

  assert_mm_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mm_read, mm_write}));

  assert_nodata_len_R8: assert property (@(posedge clk) disable iff (rst)
    tx_valid && tx_sop && !tx_data[30] |-> tx_data[9:0] == 10'd0);
endmodule

// File: tb/test_tlp_req_completer.sv
module test_tlp_req_completer;
  localparam logic [31:0] BASE   = 32'h4000_0000;
  localparam logic [12:0] BUSDEV = 13'h0A3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
  logic [31:0] rx_data = '0;
  logic rx_ready;
  logic mm_read, mm_write, mm_cfg, mm_func;
  logic [9:0] mm_addr;
  logic [3:0] mm_be;
  logic [31:0] mm_wdata;
  logic mm_ack = 1'b0;
  logic [31:0] mm_rdata = '0;
  logic tx_valid, tx_sop, tx_eop;
  logic tx_ready = 1'b0;
  logic [31:0] tx_data;

  always #5 clk = ~clk;

  tlp_req_completer #(.MEM_BASE(BASE), .WIN_LOG2(20), .CPL_BUS_DEV(BUSDEV)) i_tlp_req_completer (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_sop(rx_sop),
    .rx_eop(rx_eop), .rx_data(rx_data), .mm_read(mm_read), .mm_write(mm_write),
    .mm_cfg(mm_cfg), .mm_func(mm_func), .mm_addr(mm_addr), .mm_be(mm_be),
    .mm_wdata(mm_wdata), .mm_ack(mm_ack), .mm_rdata(mm_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_data(tx_data)
  );

  int checks = 0, fails = 0, cyc = 0;
  string cur_req = "R12";
  logic [48:0] exp_mm[$];
  logic [33:0] exp_tx[$];
  bit   seen = 0;
  int   wait_n = 0;

  function automatic logic [31:0] rdpat(input logic cfg, input logic fn, input logic [9:0] a);
    return {16'hC0DE, 4'h0, cfg, fn, a};
  endfunction

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic push_cpl(input bit dat, input logic [2:0] st, input logic [2:0] fn,
                          input logic [31:0] w1, input logic [6:0] la, input logic [31:0] d);
    exp_tx.push_back({1'b1, 1'b0, dat ? 3'b010 : 3'b000, 5'b01010, 14'd0, dat ? 10'd1 : 10'd0});
    exp_tx.push_back({1'b0, 1'b0, BUSDEV, fn, st, 1'b0, 12'd4});
    exp_tx.push_back({1'b0, !dat, w1[31:16], w1[15:8], 1'b0, la});
    if (dat) exp_tx.push_back({1'b0, 1'b1, d});
  endtask

  // Reference model written from the requirements
  task automatic model(input logic [31:0] w0, w1, w2, w3);
    logic [2:0] fmt; logic [4:0] ty; bit one; bit hit; logic [2:0] fn; logic [6:0] la;
    fmt = w0[31:29]; ty = w0[28:24]; one = (w0[9:0] == 10'd1);
    if (ty == 5'h04 || ty == 5'h05) begin
      fn = w2[18:16];
      if (ty == 5'h04 && fn < 3'd2 && one && !fmt[0]) begin
        exp_mm.push_back({fmt[1], 1'b1, fn[0], w2[11:2], w1[3:0], fmt[1] ? w3 : 32'h0});
        push_cpl(!fmt[1], 3'b000, fn, w1, 7'h0, rdpat(1'b1, fn[0], w2[11:2]));
      end else push_cpl(0, 3'b001, fn, w1, 7'h0, 32'h0);
    end else if (ty == 5'h00) begin
      hit = !fmt[0] && (w2[31:21] == BASE[31:21]);
      if (fmt[1]) begin
        if (hit && one) exp_mm.push_back({1'b1, 1'b0, w2[20], 9'd0, w2[2], w1[3:0], w3});
      end else begin
        fn = fmt[0] ? 3'd0 : {2'b00, w2[20]};
        la = fmt[0] ? {w3[6:2], 2'b00} : {w2[6:2], 2'b00};
        if (!one) push_cpl(0, 3'b100, fn, w1, la, 32'h0);
        else if (!hit) push_cpl(0, 3'b001, fn, w1, la, 32'h0);
        else begin
          exp_mm.push_back({1'b0, 1'b0, w2[20], 9'd0, w2[2], w1[3:0], 32'h0});
          push_cpl(1, 3'b000, fn, w1, la, rdpat(1'b0, w2[20], {9'd0, w2[2]}));
        end
      end
    end
  endtask

  // Memory-mapped responder, completion sink and per-cycle comparison
  always @(negedge clk) begin
    if (!rst) begin
      if (mm_ack) mm_ack = 1'b0;
      else if ((mm_read || mm_write) && !seen) begin
        if (exp_mm.size() == 0) chk({cur_req, " unexpected access"}, {mm_write, mm_addr}, 0);
        else chk({cur_req, " access"},
                 {mm_write, mm_cfg, mm_func, mm_addr, mm_be, mm_write ? mm_wdata : 32'h0},
                 exp_mm.pop_front());
        seen = 1; wait_n = 1 + (cyc % 2);
      end else if (seen) begin
        if (wait_n > 0) wait_n--;
        else begin
          mm_ack = 1'b1; mm_rdata = rdpat(mm_cfg, mm_func, mm_addr); seen = 0;
        end
      end
      if (mm_read || mm_write || tx_valid) chk("R11 rx_ready while busy", rx_ready, 0);
      tx_ready = (cyc % 3 != 1);
      if (tx_valid && tx_ready) begin
        if (exp_tx.size() == 0) chk({cur_req, " unexpected beat"}, tx_data, 0);
        else chk({cur_req, " R10 beat"}, {tx_sop, tx_eop, tx_data}, exp_tx.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog R11 actual=%0d expected<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic send(input logic [31:0] w0, w1, w2, w3, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sop = (i == 0); rx_eop = (i == n - 1);
      rx_data = (i == 0) ? w0 : (i == 1) ? w1 : (i == 2) ? w2 : (i == 3) ? w3 : 32'h0BAD_0000 + i;
      while (!rx_ready) @(negedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
  endtask

  task automatic do_tlp(input string r, input logic [31:0] w0, w1, w2, w3, input int n);
    cur_req = r;
    model(w0, w1, w2, w3);
    send(w0, w1, w2, w3, n);
    repeat (3) @(negedge clk);
    for (int k = 0; k < 200; k++) begin
      if (exp_mm.size() == 0 && exp_tx.size() == 0 && rx_ready && !tx_valid &&
          !mm_read && !mm_write) break;
      @(negedge clk);
    end
    chk({r, " pending"}, exp_mm.size() + exp_tx.size(), 0);
  endtask

  function automatic logic [31:0] h0(input logic [2:0] fmt, input logic [4:0] ty, input logic [9:0] len);
    return {fmt, ty, 14'd0, len};
  endfunction
  function automatic logic [31:0] cfgw2(input logic [2:0] fn, input logic [9:0] rg);
    return {8'h00, 5'h00, fn, 4'h0, rg, 2'b00};
  endfunction

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 reset", {rx_ready, tx_valid, mm_read, mm_write}, 4'b1000);

    do_tlp("R1", h0(3'b000, 5'h04, 10'd1), 32'h1234_110F, cfgw2(3'd0, 10'd5), 32'h0, 3);
    do_tlp("R1", h0(3'b000, 5'h04, 10'd1), 32'hBEEF_7703, cfgw2(3'd1, 10'h3FF), 32'h0, 3);
    do_tlp("R2", h0(3'b010, 5'h04, 10'd1), 32'h0042_0A0C, cfgw2(3'd1, 10'd2), 32'hDEAD_BEEF, 4);
    do_tlp("R2", h0(3'b010, 5'h04, 10'd1), 32'h0043_0B0F, cfgw2(3'd0, 10'd9), 32'h1357_9BDF, 4);
    do_tlp("R3", h0(3'b000, 5'h04, 10'd1), 32'h0101_2201, cfgw2(3'd2, 10'd1), 32'h0, 3);
    do_tlp("R3", h0(3'b010, 5'h04, 10'd1), 32'h0102_230F, cfgw2(3'd7, 10'd1), 32'h5555_0000, 4);
    do_tlp("R3", h0(3'b000, 5'h04, 10'd2), 32'h0103_240F, cfgw2(3'd0, 10'd1), 32'h0, 3);
    do_tlp("R3", h0(3'b000, 5'h05, 10'd1), 32'h0104_250F, cfgw2(3'd0, 10'd1), 32'h0, 3);
    do_tlp("R4", h0(3'b000, 5'h00, 10'd1), 32'hA001_300F, BASE, 32'h0, 3);
    do_tlp("R4", h0(3'b000, 5'h00, 10'd1), 32'hA002_310F, BASE + 32'h0010_003C, 32'h0, 3);
    do_tlp("R5", h0(3'b010, 5'h00, 10'd1), 32'hA003_3203, BASE + 32'h4, 32'hCAFE_F00D, 4);
    do_tlp("R5", h0(3'b010, 5'h00, 10'd1), 32'hA004_330F, BASE + 32'h0010_0000, 32'h0BB0_0110, 4);
    do_tlp("R6", h0(3'b010, 5'h00, 10'd2), 32'hA005_340F, BASE, 32'h1111_2222, 5);
    do_tlp("R7", h0(3'b011, 5'h10, 10'd1), 32'hA006_3500, 32'h0, 32'h0, 5);
    do_tlp("R7", h0(3'b001, 5'h14, 10'd0), 32'hA007_3600, 32'h0, 32'h0, 4);
    do_tlp("R8", h0(3'b000, 5'h00, 10'd4), 32'hA008_370F, BASE + 32'h0010_0018, 32'h0, 3);
    do_tlp("R8", h0(3'b000, 5'h00, 10'd0), 32'hA009_380F, 32'h8000_0044, 32'h0, 3);
    do_tlp("R9", h0(3'b000, 5'h00, 10'd1), 32'hA00A_390F, BASE + 32'h0020_0000, 32'h0, 3);
    do_tlp("R9", h0(3'b010, 5'h00, 10'd1), 32'hA00B_3A0F, BASE - 32'h4, 32'h7777_7777, 4);
    do_tlp("R9", h0(3'b001, 5'h00, 10'd1), 32'hA00C_3B0F, 32'h0000_0001, BASE + 32'h24, 4);
    do_tlp("R4 R10", h0(3'b000, 5'h00, 10'd1), 32'hFFFF_FF0F, BASE + 32'h0010_0074, 32'h0, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule